// File: doc/BRIEF.md
# Fetch PC Control with Branch Stall

This block owns the fetch program counter of a simple in-order pipeline that has no branch prediction. Each cycle it looks at the control-flow class of the instruction just fetched and picks the next PC. Sequential instructions step by four. Direct and register jumps redirect at once to a supplied target. A conditional branch parks the PC at zero until the branch is resolved.

Address zero is never a real instruction address, so the block uses it as a "fetch off" marker. While the PC is zero, fetch is suppressed and nothing is reported. A conditional branch always costs at least three bubble cycles. The stall output is high during each bubble so that later stages insert no-ops. The branch outcome comes back on a resolve port, either early or late. When the bubbles end, the block loads the taken target or the fall-through address. A taken target of zero is honoured, so a program can end itself by branching to address zero.

A dependency-stall input freezes the PC while an earlier instruction's result is still in flight. This applies to jumps as well.

Top module: `fetch_pc_ctrl`

## Requirements
- R1: Reset loads `pc` with the non-zero parameter START_PC (default 0x100). After reset, with `dep_stall` low, `fetch_en` is 1 and `stall` is 0.
- R2: A fetch of class 2'b00 (sequential) makes `pc` the old `pc` + 4 on the next cycle.
- R3: A fetch of class 2'b01 (conditional branch) makes `pc` zero on the next cycle. While the branch waits, `fetch_en` is 0, `stall` is 1 and `fetch_class` is ignored. The wait lasts exactly three cycles when `res_valid` arrives within them.
- R4: When the third bubble cycle ends, `pc` loads `res_target` if the resolution was taken, and the branch's own address + 4 if it was not taken. A `res_valid` pulse in any bubble cycle counts. If no `res_valid` has come by the third bubble, the wait goes on, and `pc` loads the result on the cycle after `res_valid`.
- R5: A taken resolution whose target is zero loads `pc` = 0 and ends the wait, so that `stall` = 0 and `fetch_en` = 0.
- R6: A fetch of class 2'b10 (direct jump) makes `pc` equal to `jump_target` on the next cycle, with no stall.
- R7: A fetch of class 2'b11 (register jump) makes `pc` equal to `jump_target` with bit 0 cleared on the next cycle, with no stall.
- R8: While `dep_stall` is 1 and `pc` is non-zero outside a branch wait, `fetch_en` is 0, `stall` is 1, `pc` holds its value and `fetch_class` is ignored.
- R9: While `pc` is zero outside a branch wait, `fetch_en` and `stall` are 0. `pc` stays zero until reset, whatever arrives on `fetch_class` and `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_class | input | 2 | Control-flow class of the fetched instruction |
| jump_target | input | XLEN | Target of a direct or register jump |
| dep_stall | input | 1 | Earlier result not ready; hold fetch |
| res_valid | input | 1 | Branch outcome presented this cycle |
| res_taken | input | 1 | Branch outcome is taken |
| res_target | input | XLEN | Taken-branch target |
| pc | output | XLEN | Current fetch PC (zero = fetch off) |
| fetch_en | output | 1 | Fetch the instruction at `pc` this cycle |
| stall | output | 1 | Bubble cycle; downstream inserts a no-op |

## Verification
The assertions assume three things about the inputs. `fetch_class` is a real class only when `fetch_en` is high. `jump_target` is stable in the cycle it is used. At most one `res_valid` pulse arrives per pending branch. The bench drives a class and a target only on fetch cycles, and it sends exactly one resolve pulse per branch. It sweeps that pulse across bubble cycles one to five, for both outcomes. It fills the ignored inputs with junk only in wait, stall or parked cycles, where the requirements say they have no effect.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    CF_SEQ    = 2'b00,
    CF_BRANCH = 2'b01,
    CF_JAL    = 2'b10,
    CF_JALR   = 2'b11
  } cf_class_e;
endpackage

// File: rtl/fpc_next_pc.sv
module fpc_next_pc #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   pc,
  input  fpc_pkg::cf_class_e cls,
  input  logic [XLEN-1:0]   jump_target,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   fetch_next
);
  import fpc_pkg::*;
  localparam logic [XLEN-1:0] STEP    = XLEN'(4);
  localparam logic [XLEN-1:0] LSB_CLR = ~XLEN'(1);

  assign seq_pc = pc + STEP;

  always_comb begin
    unique case (cls)
      CF_SEQ:    fetch_next = seq_pc;
      CF_BRANCH: fetch_next = '0;
      CF_JAL:    fetch_next = jump_target;
      CF_JALR:   fetch_next = jump_target & LSB_CLR;
      default:   fetch_next = seq_pc;
    endcase
  end
endmodule

// File: rtl/fpc_branch_tracker.sv
module fpc_branch_tracker #(
  parameter int XLEN    = 32,
  parameter int BUBBLES = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [XLEN-1:0] fall_pc_in,
  input  logic            res_valid,
  input  logic            res_taken,
  input  logic [XLEN-1:0] res_target,
  output logic            pend,
  output logic            done,
  output logic [XLEN-1:0] next_pc
);
  localparam int CW = $clog2(BUBBLES + 1);
  localparam logic [CW-1:0] LAST = CW'(BUBBLES - 1);

  logic [CW-1:0]   cnt;
  logic            have_res;
  logic [XLEN-1:0] fall_pc;
  logic [XLEN-1:0] res_pc;
  logic [XLEN-1:0] live_pc;

  assign live_pc = res_taken ? res_target : fall_pc;
  assign done    = pend && (cnt == LAST) && (have_res || res_valid);
  assign next_pc = have_res ? res_pc : live_pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      cnt      <= '0;
      have_res <= 1'b0;
      fall_pc  <= '0;
      res_pc   <= '0;
    end else if (start) begin
      pend     <= 1'b1;
      cnt      <= '0;
      have_res <= 1'b0;
      fall_pc  <= fall_pc_in;
    end else if (done) begin
      pend     <= 1'b0;
      have_res <= 1'b0;
    end else if (pend) begin
      if (cnt != LAST) cnt <= cnt + 1'b1;
      if (res_valid && !have_res) begin
        have_res <= 1'b1;
        res_pc   <= live_pc;
      end
    end
  end
endmodule

// File: rtl/fetch_pc_ctrl.sv
module fetch_pc_ctrl #(
  parameter int              XLEN     = 32,
  parameter int              BUBBLES  = 3,
  parameter logic [XLEN-1:0] START_PC = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      fetch_class,
  input  logic [XLEN-1:0] jump_target,
  input  logic            dep_stall,
  input  logic            res_valid,
  input  logic            res_taken,
  input  logic [XLEN-1:0] res_target,
  output logic [XLEN-1:0] pc,
  output logic            fetch_en,
  output logic            stall
);
  import fpc_pkg::*;

  cf_class_e       cls;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] fetch_next;
  logic            br_pend;
  logic            br_done;
  logic [XLEN-1:0] br_pc;
  logic            br_start;
  logic            pc_live;

  assign cls      = cf_class_e'(fetch_class);
  assign pc_live  = (pc != '0);
  assign fetch_en = pc_live && !dep_stall && !br_pend;
  assign stall    = br_pend || (dep_stall && pc_live);
  assign br_start = fetch_en && (cls == CF_BRANCH);

  fpc_next_pc #(.XLEN(XLEN)) u_next (
    .pc(pc), .cls(cls), .jump_target(jump_target),
    .seq_pc(seq_pc), .fetch_next(fetch_next)
  );

  fpc_branch_tracker #(.XLEN(XLEN), .BUBBLES(BUBBLES)) u_br (
    .clk(clk), .rst(rst), .start(br_start), .fall_pc_in(seq_pc),
    .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
    .pend(br_pend), .done(br_done), .next_pc(br_pc)
  );

  always_ff @(posedge clk) begin
    if (rst)           pc <= START_PC;
    else if (br_done)  pc <= br_pc;
    else if (fetch_en) pc <= fetch_next;
  end
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      fetch_class,
  input logic [XLEN-1:0] jump_target,
  input logic            dep_stall,
  input logic [XLEN-1:0] pc,
  input logic            fetch_en,
  input logic            stall,
  input logic            br_pend
);
  p_zero_no_fetch_r9: assert property (@(posedge clk) disable iff (rst)
    (pc == '0) |-> !fetch_en);

  p_branch_parks_r3: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && fetch_class == 2'b01) |=> (pc == '0 && stall));

  p_wait_blocks_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    br_pend |-> (!fetch_en && stall));

  p_jal_target_r6: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && fetch_class == 2'b10) |=> (pc == $past(jump_target)));

  p_jalr_lsb_r7: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && fetch_class == 2'b11) |=> (pc[0] == 1'b0));

  p_dep_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (dep_stall && pc != '0 && !br_pend) |=> (pc == $past(pc)));

  p_parked_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (pc == '0 && !br_pend) |=> (pc == '0 && !stall));
endmodule

bind fetch_pc_ctrl fpc_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .fetch_class(fetch_class), .jump_target(jump_target),
  .dep_stall(dep_stall), .pc(pc), .fetch_en(fetch_en), .stall(stall),
  .br_pend(br_pend)
);

// File: tb/tb_fetch_pc_ctrl.sv
`timescale 1ns/100ps
module tb_fetch_pc_ctrl;
  localparam int XLEN = 32;
  localparam logic [XLEN-1:0] START = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] fetch_class = 2'b00;
  logic [XLEN-1:0] jump_target = '0;
  logic dep_stall = 1'b0;
  logic res_valid = 1'b0;
  logic res_taken = 1'b0;
  logic [XLEN-1:0] res_target = '0;
  logic [XLEN-1:0] pc;
  logic fetch_en, stall;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fetch_pc_ctrl #(.XLEN(XLEN), .BUBBLES(3), .START_PC(START)) dut (
    .clk(clk), .rst(rst), .fetch_class(fetch_class), .jump_target(jump_target),
    .dep_stall(dep_stall), .res_valid(res_valid), .res_taken(res_taken),
    .res_target(res_target), .pc(pc), .fetch_en(fetch_en), .stall(stall)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; fetch_class = 2'b00; dep_stall = 1'b0; res_valid = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic run_branch(logic tk, logic [XLEN-1:0] tgt, int k);
    logic [XLEN-1:0] bpc;
    logic [XLEN-1:0] exp_pc;
    int last;
    bpc = pc;
    exp_pc = tk ? tgt : bpc + 4;
    last = (k > 3) ? k : 3;
    fetch_class = 2'b01;
    step();
    for (int b = 1; b <= last; b++) begin
      chk("R3 pc parked", pc, '0);
      chk("R3 stall in bubble", {31'b0, stall}, 1);
      chk("R3 fetch_en off", {31'b0, fetch_en}, 0);
      fetch_class = 2'(b);
      jump_target = 32'hDEAD_0000 + b;
      res_valid = (b == k);
      res_taken = (b == k) ? tk : ~tk;
      res_target = (b == k) ? tgt : 32'h0BAD_0000;
      step();
    end
    res_valid = 1'b0;
    fetch_class = 2'b00;
    chk("R4 resolved pc", pc, exp_pc);
    if (exp_pc != '0) chk("R4 stall ends", {31'b0, stall}, 0);
  endtask

  initial begin
    do_reset();
    chk("R1 reset pc", pc, START);
    chk("R1 fetch_en", {31'b0, fetch_en}, 1);
    chk("R1 stall", {31'b0, stall}, 0);

    for (int i = 1; i <= 8; i++) begin
      fetch_class = 2'b00;
      step();
      chk("R2 sequential", pc, START + 32'(4 * i));
    end

    for (int tk = 0; tk < 2; tk++) begin
      for (int k = 1; k <= 5; k++) begin
        run_branch(tk[0], 32'h0000_2000 + 32'(k * 16), k);
      end
    end

    for (int i = 0; i < 6; i++) begin
      fetch_class = 2'b10;
      jump_target = 32'h0000_3000 + 32'(i * 20) + 32'(i);
      step();
      chk("R6 jal target", pc, 32'h0000_3000 + 32'(i * 20) + 32'(i));
      chk("R6 no stall", {31'b0, stall}, 0);
    end

    for (int i = 0; i < 6; i++) begin
      fetch_class = 2'b11;
      jump_target = 32'h0000_4001 + 32'(i * 6);
      step();
      chk("R7 jalr lsb cleared", pc, (32'h0000_4001 + 32'(i * 6)) & ~32'h1);
      chk("R7 no stall", {31'b0, stall}, 0);
    end

    begin
      logic [XLEN-1:0] held;
      held = pc;
      for (int c = 0; c < 4; c++) begin
        dep_stall = 1'b1;
        fetch_class = 2'(c);
        jump_target = 32'h0000_5000;
        #0.1;
        chk("R8 fetch_en low", {31'b0, fetch_en}, 0);
        chk("R8 stall high", {31'b0, stall}, 1);
        step();
        chk("R8 pc held", pc, held);
      end
      dep_stall = 1'b0;
      fetch_class = 2'b00;
      step();
      chk("R8 resume", pc, held + 4);
    end

    run_branch(1'b1, '0, 2);
    chk("R5 stall low at zero", {31'b0, stall}, 0);
    chk("R5 fetch_en low at zero", {31'b0, fetch_en}, 0);

    for (int c = 0; c < 4; c++) begin
      fetch_class = 2'(c);
      jump_target = 32'h0000_6000;
      res_valid = 1'b1; res_taken = 1'b1; res_target = 32'h0000_7000;
      dep_stall = c[0];
      step();
      chk("R9 pc stays zero", pc, '0);
      chk("R9 no fetch", {31'b0, fetch_en}, 0);
      chk("R9 no stall", {31'b0, stall}, 0);
    end
    res_valid = 1'b0; dep_stall = 1'b0;

    do_reset();
    chk("R1 reset after park", pc, START);
    fetch_class = 2'b10; jump_target = '0;
    step();
    chk("R6 jal to zero", pc, '0);
    chk("R9 parked after jal", {31'b0, fetch_en}, 0);

    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 20000; t++) begin
      if (done) break;
      @(posedge clk);
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule